// File: doc/BRIEF.md
# Asynchronous Serial Baud Tick Generator

This block derives the timing events an asynchronous serial transmitter and receiver need from a single fast peripheral clock. A coarse prescaler divides the clock by 1, 4, 16 or 64. A reload divider then stretches the prescaled clock by a programmable count. An optional phase accumulator removes a fraction of the divider events so that the bit rate can be trimmed finer than the integer reload allows. The surviving events are the base ticks. A symbol phase counter groups 16, 8 or 6 base ticks into one bit period. It marks the middle of each bit for the receiver's sampler and the end of each bit for both directions.

All timing state is cleared synchronously while the run input is low. Software or a wrapping controller changes the configuration only while the block is stopped. Raising the run input again starts the first bit with a full period.

Top module: `baud_tick_gen`

## Requirements
- R1: While `run` is low, `base_tick`, `mid_strobe` and `edge_strobe` are all 0.
- R2: `presc_sel` encoding 2'b00, 2'b01, 2'b10, 2'b11 divides the clock by 1, 4, 16, 64 respectively. The first prescaled event falls in cycle div-1 after run rises.
- R3: The reload divider produces one wrap every `reload`+1 prescaled events.
- R4: With `dbl_rate`=0 and `six_mode`=0, a base-tick candidate occurs on every second divider wrap. With `dbl_rate`=1, it occurs on every wrap. The candidate period is therefore P = (reload+1)·div·(2 or 1) clock cycles, and candidate k falls in cycle k·P-1 after run rises.
- R5: One bit period is 16 base ticks when `half_os`=0 and 8 when `half_os`=1. `six_mode`=1 overrides both to 6 base ticks and also selects the every-wrap candidate rate.
- R6: With `frac_en`=1, an 8-bit accumulator starting at 0 adds `frac_duty` on each candidate. The candidate becomes a base tick only when that addition carries out of bit 7, so `frac_duty`=0 yields no ticks. With `frac_en`=0, every candidate is a base tick.
- R7: `mid_strobe` is high with the base tick that completes tick N/2 of a bit. `edge_strobe` is high with the base tick that completes tick N. Both are high only together with `base_tick`, and never together with each other.
- R8: Dropping and re-raising `run` restarts the prescaler, divider, accumulator and phase, so the timing after the new rise matches a fresh start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Port enable; low clears all timing state |
| presc_sel | input | 2 | Prescaler select (÷1, ÷4, ÷16, ÷64) |
| reload | input | 8 | Reload divider value |
| dbl_rate | input | 1 | Base-tick candidate on every wrap instead of every second |
| half_os | input | 1 | 8 base ticks per bit instead of 16 |
| six_mode | input | 1 | 6 base ticks per bit at double rate |
| frac_en | input | 1 | Enable fractional tick removal |
| frac_duty | input | 8 | Accumulator increment; kept ratio is frac_duty/256 |
| base_tick | output | 1 | Base clock tick, one cycle wide |
| mid_strobe | output | 1 | Mid-bit sample strobe |
| edge_strobe | output | 1 | Bit boundary strobe |

## Verification
The assertions assume that the configuration inputs stay constant while `run` is high. The phase-count and spacing properties judge each event against the current settings, so a change mid-run would be reported as a fault. The stimulus applies every configuration while `run` is low and holds it for the whole enabled interval. Restarts are tested by dropping `run` part way through a bit. Modulation is exercised with a non-trivial duty and with duty 0. The bench compares every clock cycle against closed-form event positions.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int PRE_W   = 6;
  localparam int PHASE_W = 5;

  // clock division ratio chosen by the prescaler select
  function automatic logic [PRE_W:0] presc_div(input logic [1:0] sel);
    return (PRE_W+1)'(1) << {sel, 1'b0};
  endfunction

  // base ticks in one bit period
  function automatic logic [PHASE_W-1:0] bit_len(input logic half_os, input logic six_mode);
    if (six_mode) return PHASE_W'(6);
    else if (half_os) return PHASE_W'(8);
    else return PHASE_W'(16);
  endfunction

  function automatic logic [PHASE_W-1:0] mid_index(input logic [PHASE_W-1:0] n);
    return (n >> 1) - PHASE_W'(1);
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       pre_tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W:0]   div_full;
  logic [PRE_W-1:0] div_m1;

  assign div_full = presc_div(sel);
  assign div_m1   = div_full[PRE_W-1:0] - PRE_W'(1);
  assign pre_tick = run && (cnt_q == div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (pre_tick)   cnt_q <= '0;
    else                 cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/baud_reload_div.sv
module baud_reload_div #(
  parameter int RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                pre_tick,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                fast,
  output logic                wrap,
  output logic                cand
);
  logic [RELOAD_W-1:0] cnt_q;
  logic                half_q;

  assign wrap = pre_tick && (cnt_q == '0);
  assign cand = wrap && (fast || half_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= reload;
      half_q <= 1'b0;
    end else if (pre_tick) begin
      cnt_q  <= wrap ? reload : cnt_q - RELOAD_W'(1);
      if (wrap) half_q <= ~half_q;
    end
  end
endmodule

// File: rtl/baud_frac_mod.sv
module baud_frac_mod #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cand,
  input  logic              frac_en,
  input  logic [DUTY_W-1:0] duty,
  output logic              keep
);
  logic [DUTY_W-1:0] acc_q;
  logic [DUTY_W:0]   sum;

  assign sum  = {1'b0, acc_q} + {1'b0, duty};
  assign keep = cand && (!frac_en || sum[DUTY_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  acc_q <= '0;
    else if (!run)               acc_q <= '0;
    else if (cand && frac_en)    acc_q <= sum[DUTY_W-1:0];
  end
endmodule

// File: rtl/baud_bit_phase.sv
module baud_bit_phase
  import baud_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic half_os,
  input  logic six_mode,
  output logic mid,
  output logic last
);
  logic [PHASE_W-1:0] cnt_q;
  logic [PHASE_W-1:0] n_len;
  logic               at_end;

  assign n_len  = bit_len(half_os, six_mode);
  assign at_end = (cnt_q == n_len - PHASE_W'(1));
  assign mid    = tick && (cnt_q == mid_index(n_len));
  assign last   = tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= at_end ? '0 : cnt_q + PHASE_W'(1);
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int RELOAD_W = 8,
  parameter int DUTY_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [1:0]          presc_sel,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                dbl_rate,
  input  logic                half_os,
  input  logic                six_mode,
  input  logic                frac_en,
  input  logic [DUTY_W-1:0]   frac_duty,
  output logic                base_tick,
  output logic                mid_strobe,
  output logic                edge_strobe
);
  logic pre_tick;
  logic div_wrap;
  logic cand_evt;
  logic fast;

  assign fast = dbl_rate || six_mode;

  baud_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(presc_sel), .pre_tick(pre_tick)
  );

  baud_reload_div #(.RELOAD_W(RELOAD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_tick(pre_tick), .reload(reload),
    .fast(fast), .wrap(div_wrap), .cand(cand_evt)
  );

  baud_frac_mod #(.DUTY_W(DUTY_W)) u_mod (
    .clk(clk), .rst_n(rst_n), .run(run), .cand(cand_evt), .frac_en(frac_en),
    .duty(frac_duty), .keep(base_tick)
  );

  baud_bit_phase u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(base_tick), .half_os(half_os),
    .six_mode(six_mode), .mid(mid_strobe), .last(edge_strobe)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
  import baud_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic [1:0] presc_sel,
  input logic       dbl_rate,
  input logic       half_os,
  input logic       six_mode,
  input logic       frac_en,
  input logic       pre_tick,
  input logic       div_wrap,
  input logic       cand_evt,
  input logic       base_tick,
  input logic       mid_strobe,
  input logic       edge_strobe
);
  logic [PHASE_W-1:0] seen_q;
  logic [PHASE_W-1:0] n_len;
  assign n_len = bit_len(half_os, six_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_q <= '0;
    else if (!run)      seen_q <= '0;
    else if (base_tick) seen_q <= (seen_q == n_len - PHASE_W'(1)) ? '0 : seen_q + PHASE_W'(1);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(base_tick || mid_strobe || edge_strobe)); // R1
  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pre_tick && presc_sel != 2'b00) |=> !pre_tick); // R2
  AST_TICK_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |-> div_wrap); // R3
  AST_FAST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (div_wrap && (dbl_rate || six_mode) && !frac_en) |-> base_tick); // R4
  AST_EDGE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_strobe |-> (seen_q == n_len - PHASE_W'(1))); // R5
  AST_KEEP_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |-> cand_evt); // R6
  AST_MID_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    mid_strobe |-> (base_tick && seen_q == (n_len >> 1) - PHASE_W'(1))); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mid_strobe && edge_strobe)); // R7
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .presc_sel(presc_sel), .dbl_rate(dbl_rate),
  .half_os(half_os), .six_mode(six_mode), .frac_en(frac_en), .pre_tick(pre_tick),
  .div_wrap(div_wrap), .cand_evt(cand_evt), .base_tick(base_tick),
  .mid_strobe(mid_strobe), .edge_strobe(edge_strobe)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [1:0] presc_sel = 2'b00;
  logic [7:0] reload = 8'd0;
  logic       dbl_rate = 1'b0, half_os = 1'b0, six_mode = 1'b0, frac_en = 1'b0;
  logic [7:0] frac_duty = 8'd0;
  logic       base_tick, mid_strobe, edge_strobe;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .presc_sel(presc_sel), .reload(reload),
    .dbl_rate(dbl_rate), .half_os(half_os), .six_mode(six_mode), .frac_en(frac_en),
    .frac_duty(frac_duty), .base_tick(base_tick), .mid_strobe(mid_strobe),
    .edge_strobe(edge_strobe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quiet(input string req, input int cycles);
    int bad = 0;
    run = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk); #1;
      if (base_tick || mid_strobe || edge_strobe) bad++;
    end
    check(req, bad, 0);
  endtask

  // configure while stopped, start, compare each cycle to closed-form timing
  task automatic run_cfg(input string req, input logic [1:0] sel, input int rl,
                         input logic dbl, input logic h8, input logic s6,
                         input logic fe, input int duty, input int cycles,
                         input int exp_ticks);
    longint div, per, n, j, kept, bad;
    logic eb, em, ee;
    @(negedge clk);
    run = 1'b0;
    presc_sel = sel; reload = rl[7:0]; dbl_rate = dbl; half_os = h8;
    six_mode = s6; frac_en = fe; frac_duty = duty[7:0];
    repeat (3) @(negedge clk);
    div  = longint'(1) << (2 * sel);
    per  = (rl + 1) * div * ((dbl || s6) ? 1 : 2);
    n    = s6 ? 6 : (h8 ? 8 : 16);
    kept = 0; bad = 0;
    run  = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      #1;
      eb = 1'b0;
      if (((c + 1) % per) == 0) begin
        j  = (c + 1) / per;
        eb = !fe || (((j * duty) >> 8) != (((j - 1) * duty) >> 8));
      end
      em = 1'b0; ee = 1'b0;
      if (eb) begin
        kept++;
        em = (kept % n) == n / 2;
        ee = (kept % n) == 0;
      end
      if (base_tick !== eb || mid_strobe !== em || edge_strobe !== ee) begin
        if (bad == 0)
          $display("FAIL %s: cycle %0d actual b/m/e=%b%b%b expected %b%b%b",
                   req, c, base_tick, mid_strobe, edge_strobe, eb, em, ee);
        bad++;
      end
      @(negedge clk);
    end
    run = 1'b0;
    check({req, " cycle match"}, int'(bad), 0);
    if (exp_ticks >= 0) check({req, " tick count"}, int'(kept), exp_ticks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset base", int'(base_tick), 0);
    check("R1 reset strobes", int'(mid_strobe | edge_strobe), 0);
    rst_n = 1'b1;
    quiet("R1 stopped", 10);
    // R3 R4 R7: div 1, reload 3, normal rate, 16 per bit -> P=8
    run_cfg("R3 R4 R7 normal", 2'b00, 3, 1'b0, 1'b0, 1'b0, 1'b0, 0, 300, 37);
    // R2 R4: div 4, reload 1, double rate -> P=8
    run_cfg("R2 R4 div4 double", 2'b01, 1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 200, 25);
    // R2 R5: div 16, reload 0, normal, 8 per bit -> P=32
    run_cfg("R2 R5 div16 half", 2'b10, 0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 600, 18);
    // R2: div 64, reload 0, double -> P=64
    run_cfg("R2 div64", 2'b11, 0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1300, 20);
    // R5: six mode, reload 2 -> P=3, 6 per bit
    run_cfg("R5 six", 2'b00, 2, 1'b0, 1'b0, 1'b1, 1'b0, 0, 120, 40);
    // R6: P=1, duty 96 -> floor(600*96/256)=225 ticks
    run_cfg("R6 frac 96", 2'b00, 0, 1'b1, 1'b0, 1'b0, 1'b1, 96, 600, 225);
    run_cfg("R6 frac 0", 2'b00, 0, 1'b1, 1'b0, 1'b0, 1'b1, 0, 300, 0);
    // R8: stop part way through a bit, then a fresh start must match
    run_cfg("R8 partial", 2'b00, 4, 1'b0, 1'b1, 1'b0, 1'b1, 200, 77, -1);
    quiet("R1 after stop", 6);
    run_cfg("R8 restart", 2'b00, 4, 1'b0, 1'b1, 1'b0, 1'b1, 200, 400, 31);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule